// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block lets a clocked host perform single-byte reads and writes on an external asynchronous static RAM of 2^17 bytes. The host raises a request level together with an address, a direction bit and a write byte. The controller latches these, runs the memory's enable and strobe pins through a fixed, cycle-counted sequence and returns a one-cycle acknowledge. On a read, the acknowledge comes with the captured byte.

The memory needs two chip selects of opposite polarity, an active-low output enable and an active-low write strobe. The data pins are split into an output byte, a drive enable and an input byte, and a pad ring outside this block turns them into a three-state bus. Every analogue timing minimum is a nanosecond parameter. Each one is rounded up to whole clock cycles against the clock-period parameter.

Top module: `sram_port_ctl`

## Requirements
- R1: While idle and out of reset, the memory is deselected. This means the active-low select is 1, the active-high select is 0, output enable and write strobe are both 1 (inactive), the data drive enable is 0 and the acknowledge is 0.
- R2: A read (direction bit 0) keeps the memory selected with output enable at 0, write strobe at 1 and the drive enable at 0 for exactly ACC cycles. ACC is the larger of the access time and the output-enable-to-data time, rounded up to whole clock periods. The input byte is captured at the end of that window.
- R3: A write (direction bit 1) holds the write strobe at 0 for exactly PW cycles while the memory is selected, output enable is 1 and the latched byte is driven. PW is the largest of the strobe width, the data set-up time, the address-to-write-end time and the cycle time less one period, each rounded up, and never less than 1.
- R4: After the write strobe rises, the memory stays selected and the byte stays driven for one more cycle, unchanged through the whole strobe.
- R5: The controller never drives the data pins while output enable is 0. After a read, output enable stays at 1 for at least TURN cycles before the next write. TURN is the output-disable time rounded up, and at least 1.
- R6: The acknowledge is high for exactly one cycle per transaction. A read's acknowledge comes ACC+1 rising edges after the edge that accepts the request, counting the accepting edge. A write's acknowledge comes PW+2 edges after it.
- R7: The read byte output updates only when a read completes. A write leaves it unchanged.
- R8: Address, direction and write byte are latched on acceptance. The host may change them later in the transaction with no effect on the memory address pins, the driven byte or the stored data.
- R9: At the cycle of every acknowledge, and for at least one cycle before the next request is taken, the memory is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Transaction request level, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte from the last completed read |
| mem_addr | output | 17 | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | 8 | Byte to drive on the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Byte seen on the data pins |

## Verification
A sequencer stuck in the wrong state shows at the pins within one clock. The selects, strobes or drive enable take a combination the enable table forbids, or the drive enable rises while output enable is low. A window counter off by one changes the strobe or access width and moves the acknowledge by one edge; the cycle-by-cycle pin trace and the latency count both catch that. A capture taken too early or into the wrong register returns the wrong byte at the next acknowledge, so every read-back compares against a byte written earlier.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_HOLD,
        ST_GAP
    } state_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } pins_t;

endpackage

// File: rtl/sram_port_timer.sv
module sram_port_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_port_decode.sv
module sram_port_decode
    import sram_port_pkg::*;
(
    input  state_e st,
    output pins_t  pins
);
    always_comb begin
        pins = '{sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
        unique case (st)
            ST_READ:  pins = '{sel_n: 1'b0, sel: 1'b1, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
            ST_WRITE: pins = '{sel_n: 1'b0, sel: 1'b1, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
            ST_HOLD:  pins = '{sel_n: 1'b0, sel: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
            default:  ;
        endcase
    end
endmodule

// File: rtl/sram_port_ctl.sv
module sram_port_ctl
    import sram_port_pkg::*;
#(
    parameter int ADDR_W          = 17,
    parameter int DATA_W          = 8,
    parameter int CLK_NS          = 10,
    parameter int T_ACCESS_NS     = 15,
    parameter int T_OE_DATA_NS    = 7,
    parameter int T_CYCLE_NS      = 15,
    parameter int T_WPULSE_NS     = 12,
    parameter int T_DSETUP_NS     = 8,
    parameter int T_ADDR_WEND_NS  = 12,
    parameter int T_OE_OFF_NS     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    function automatic int ceil_cyc(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int ACC_CYC  = max2(max2(ceil_cyc(T_ACCESS_NS), ceil_cyc(T_OE_DATA_NS)), 1);
    localparam int PW_CYC   = max2(max2(max2(ceil_cyc(T_WPULSE_NS), ceil_cyc(T_DSETUP_NS)),
                                        max2(ceil_cyc(T_ADDR_WEND_NS), ceil_cyc(T_CYCLE_NS) - 1)), 1);
    localparam int TURN_CYC = max2(ceil_cyc(T_OE_OFF_NS), 1);
    localparam int MAX_CYC  = max2(max2(ACC_CYC, PW_CYC), TURN_CYC);
    localparam int CW       = $clog2(MAX_CYC + 1);

    typedef struct packed {
        state_e            st;
        pins_t             pins;
        logic              ack;
        logic [DATA_W-1:0] rdata;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } regs_t;

    regs_t         r_d, r_q;
    pins_t         pins_next;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_zero;

    sram_port_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    sram_port_decode i_decode (
        .st   (r_d.st),
        .pins (pins_next)
    );

    always_comb begin
        r_d      = r_q;
        r_d.ack  = 1'b0;
        t_load   = 1'b0;
        t_val    = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    t_load    = 1'b1;
                    if (req_write) begin
                        r_d.st = ST_WRITE;
                        t_val  = CW'(PW_CYC - 1);
                    end else begin
                        r_d.st = ST_READ;
                        t_val  = CW'(ACC_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (t_zero) begin
                    r_d.rdata = mem_dq_in;
                    r_d.ack   = 1'b1;
                    r_d.st    = ST_GAP;
                    t_load    = 1'b1;
                    t_val     = CW'(TURN_CYC - 1);
                end
            end
            ST_WRITE: begin
                if (t_zero) r_d.st = ST_HOLD;
            end
            ST_HOLD: begin
                r_d.ack = 1'b1;
                r_d.st  = ST_GAP;
                t_load  = 1'b1;
                t_val   = '0;
            end
            ST_GAP: begin
                if (t_zero) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.pins = pins_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.pins  <= '{sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
            r_q.ack   <= 1'b0;
            r_q.rdata <= '0;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack        = r_q.ack;
    assign rdata      = r_q.rdata;
    assign mem_addr   = r_q.addr;
    assign mem_dq_out = r_q.wdata;
    assign mem_sel_n  = r_q.pins.sel_n;
    assign mem_sel    = r_q.pins.sel;
    assign mem_oe_n   = r_q.pins.oe_n;
    assign mem_we_n   = r_q.pins.we_n;
    assign mem_dq_oe  = r_q.pins.dq_oe;
endmodule

// File: rtl/sram_port_chk.sv
module sram_port_chk #(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int PW_CYC   = 2,
    parameter int TURN_CYC = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    logic        selected;
    logic [15:0] we_lo_cnt;
    logic [15:0] oe_hi_cnt;

    assign selected = !mem_sel_n && mem_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_cnt <= '0;
            oe_hi_cnt <= 16'hffff;
        end else begin
            we_lo_cnt <= !mem_we_n ? we_lo_cnt + 1'b1 : '0;
            if (!mem_oe_n)                oe_hi_cnt <= '0;
            else if (oe_hi_cnt != 16'hffff) oe_hi_cnt <= oe_hi_cnt + 1'b1;
        end
    end

    p_sel_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_n == !mem_sel);

    p_read_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (selected && mem_we_n && !mem_dq_oe));

    p_we_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (selected && mem_oe_n && mem_dq_oe));

    p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_cnt >= 16'(PW_CYC)));

    p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    p_no_contend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_hi_cnt >= 16'(TURN_CYC)));

    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && $past(selected)) |-> $stable(mem_addr));

    p_ack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (!selected && mem_we_n && mem_oe_n && !mem_dq_oe));
endmodule

bind sram_port_ctl sram_port_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PW_CYC   (PW_CYC),
    .TURN_CYC (TURN_CYC)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack        (ack),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_port_ctl.sv
`timescale 1ns/1ps
module test_sram_port_ctl;
    localparam int CLK_PERIOD = 10;
    // expected cycle counts worked out from the default ns minimums at 10 ns
    localparam int E_ACC  = 2;   // 15 ns access -> 2 cycles
    localparam int E_PW   = 2;   // 12 ns strobe -> 2 cycles
    localparam int E_TURN = 1;   // 7 ns disable -> 1 cycle
    localparam int T_WPULSE_NS = 12;
    localparam int T_DSETUP_NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ack;
    logic [7:0]  rdata;
    logic [16:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_port_ctl i_sram_port_ctl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // behavioural memory following the enable table
    logic [7:0] mem [int];
    realtime t_we_fall = 0.0;
    realtime t_dq_chg = 0.0;
    logic sel_now;
    assign sel_now = !mem_sel_n && mem_sel;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(mem_dq_out) t_dq_chg = $realtime;
    always @(negedge mem_we_n) t_we_fall = $realtime;
    always @(posedge mem_we_n) begin
        if (sel_now && rst_n) begin
            check(($realtime - t_we_fall) >= T_WPULSE_NS, "R3 strobe width ns",
                  int'($realtime - t_we_fall), T_WPULSE_NS);
            check(($realtime - t_dq_chg) >= T_DSETUP_NS, "R3 data setup ns",
                  int'($realtime - t_dq_chg), T_DSETUP_NS);
            mem[int'(mem_addr)] = mem_dq_out;
        end
    end
    always @(mem_addr or mem_oe_n or mem_we_n or sel_now or mem_dq_oe) begin
        if (sel_now && !mem_oe_n && mem_we_n)
            mem_dq_in = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in = 8'hxx;
    end

    always @(negedge clk) if (rst_n && mem_dq_oe && !mem_oe_n)
        check(1'b0, "R5 bus contention", 1, 0);

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic bit idle_pins();
        return mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe;
    endfunction

    task automatic do_write(input logic [16:0] a, input logic [7:0] d, input bit scramble);
        int n = 0, we_lo = 0, hold = 0;
        logic [7:0] keep_rd = rdata;
        @(negedge clk);
        req = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        do begin
            @(negedge clk);
            n++;
            if (scramble) begin req_addr = ~a; req_wdata = ~d; end
            if (!mem_we_n) begin
                we_lo++;
                check(mem_oe_n && mem_dq_oe && sel_now && mem_dq_out == d, "R3 pins in strobe",
                      mem_dq_out, d);
            end
            if (sel_now && mem_we_n) begin
                hold++;
                check(mem_dq_oe && mem_dq_out == d, "R4 hold drive", mem_dq_out, d);
            end
            if (sel_now) check(mem_addr == a, "R8 addr latched", mem_addr, a);
        end while (!ack && n < 50);
        check(n == E_PW + 2, "R6 write latency", n, E_PW + 2);
        check(we_lo == E_PW, "R3 strobe cycles", we_lo, E_PW);
        check(hold == 1, "R4 hold cycles", hold, 1);
        check(rdata == keep_rd, "R7 rdata after write", rdata, keep_rd);
        check(idle_pins(), "R9 deselect at ack", 0, 1);
        req = 1'b0;
        @(negedge clk);
        check(!ack, "R6 ack one cycle", ack, 0);
        check(idle_pins(), "R9 gap deselected", 0, 1);
    endtask

    task automatic do_read(input logic [16:0] a, input logic [7:0] exp, input bit scramble);
        int n = 0, acc = 0;
        @(negedge clk);
        req = 1'b1; req_write = 1'b0; req_addr = a;
        do begin
            @(negedge clk);
            n++;
            if (scramble) begin req_addr = ~a; req_write = 1'b1; end
            if (sel_now) begin
                acc++;
                check(!mem_oe_n && mem_we_n && !mem_dq_oe, "R2 read pins", mem_oe_n, 0);
                check(mem_addr == a, "R8 read addr latched", mem_addr, a);
            end
        end while (!ack && n < 50);
        check(n == E_ACC + 1, "R6 read latency", n, E_ACC + 1);
        check(acc == E_ACC, "R2 access cycles", acc, E_ACC);
        check(rdata == exp, "R2 read data", rdata, exp);
        check(idle_pins(), "R9 deselect at ack", 0, 1);
        req = 1'b0;
        for (int i = 0; i < E_TURN; i++) begin
            @(negedge clk);
            check(mem_oe_n && !mem_dq_oe, "R5 turnaround", mem_oe_n, 1);
        end
        check(!ack, "R6 ack one cycle", ack, 0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(idle_pins() && !ack, "R1 reset idle", 0, 1);
        end
    endtask

    task automatic t_basic();
        do_write(17'h00000, 8'h5a, 1'b0);
        do_read(17'h00000, 8'h5a, 1'b0);
    endtask

    task automatic t_patterns();
        do_write(17'h1ffff, 8'hff, 1'b0);
        do_write(17'h0aaaa, 8'h00, 1'b0);
        do_write(17'h15555, 8'ha5, 1'b0);
        do_read(17'h1ffff, 8'hff, 1'b0);
        do_read(17'h0aaaa, 8'h00, 1'b0);
        do_read(17'h15555, 8'ha5, 1'b0);
    endtask

    task automatic t_latch();
        do_write(17'h00123, 8'h3c, 1'b1);
        do_read(17'h00123, 8'h3c, 1'b1);
        do_read(17'h1fedc, 8'h00, 1'b0);   // R8: complement address never written
    endtask

    task automatic t_rdata_hold();
        do_read(17'h15555, 8'ha5, 1'b0);
        do_write(17'h00001, 8'h77, 1'b0);  // R7 checked inside: rdata stays a5
        check(rdata == 8'ha5, "R7 rdata kept", rdata, 8'ha5);
        do_read(17'h00001, 8'h77, 1'b0);
    endtask

    task automatic t_back_to_back();
        // R5 and R9: write directly after read; idle pins checked between
        do_read(17'h00001, 8'h77, 1'b0);
        do_write(17'h00002, 8'h81, 1'b0);
        do_read(17'h00002, 8'h81, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(idle_pins() && !ack && rdata == 8'h00, "R1 in reset", 0, 1);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_patterns();
        t_latch();
        t_rdata_hold();
        t_back_to_back();
        repeat (4) @(negedge clk);
        check(idle_pins(), "R1 idle at end", 0, 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule